// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Decoder with Core Boot Sequencer

This block turns a 64-bit inter-processor interrupt command into per-core actions for a small multiprocessor interrupt controller. It also keeps a boot state for each of up to `N` cores. Commands arrive in one of two ways. In compact mode, software first writes the upper 32 bits to a holding register and then writes the lower 32 bits, and that second write issues the command. In extended mode, the whole 64-bit command arrives in a single write.

Fixed and non-maskable commands are delivered to a set of cores. That set comes from a two-bit destination shorthand. The block serves the selected cores one per cycle, lowest index first, and holds `busy` high until the last one is served.

INIT and STARTUP commands drive the boot state machine. A core moves from held-in-init, to waiting for a start command, to running. When a STARTUP command is honoured, the block emits a start request that carries the core number and a page-aligned start address. Any command the block cannot handle raises a one-cycle `unhandled` pulse, so the surrounding logic can pass it on.

Top module: `ipi_sequencer`

## Requirements
- R1: After reset, core 0 is RUNNING and every other core is INIT. `core_state` holds two bits per core, core i at bits [2i+1:2i], with INIT=00, WAIT=01 and RUNNING=10. After reset `busy`, `fix_req`, `nmi_pulse`, `start_req` and `unhandled` are all low.
- R2: In compact mode (`ext_mode`=0):
  - A `hi_wr` stores `hi_data` and causes no output activity.
  - A `lo_wr` issues the command {stored high, `lo_data`}.
  - The destination is command bits [63:56].
- R3: In extended mode (`ext_mode`=1):
  - A `cmd_wr` issues `cmd_data` directly, and the destination is bits [63:32].
  - `hi_wr` and `lo_wr` are ignored and leave the stored high half unchanged.
- R4: The delivery mode is command bits [10:8]: fixed=000, NMI=100, INIT=101, STARTUP=110. Any other value produces a one-cycle `unhandled` pulse in the cycle after the issuing edge, and nothing else.
- R5: For fixed delivery, `fix_vec` carries the vector in bits [7:0] while a core is being served. The shorthand is bits [19:18]:
  - 00 explicit destination: the named core, whatever its boot state. A destination of N or more selects no core.
  - 01 self: the core given on `src_core`.
- R6: Shorthand 10 selects every RUNNING core. Shorthand 11 selects every RUNNING core except `src_core`.
- R7: Fan-out takes one cycle per selected core.
  - The first core is served in the cycle after the issuing edge.
  - Cores are served in ascending index, with one core per cycle.
  - `busy` stays high until the last core has been served.
  - A command issued while `busy` is high is dropped.
- R8: NMI delivery selects cores by the same rules as fixed delivery, but gives each selected core a one-cycle `nmi_pulse` instead of a `fix_req`.
- R9: INIT behaviour:
  - An INIT with level bit 14 = 0 is ignored.
  - An asserting INIT from core 0 to a destination in 1..N-1 moves that core from INIT to WAIT.
  - A core in WAIT or RUNNING is not affected.
- R10: A STARTUP from core 0 to a destination in 1..N-1 is honoured only when the target is in WAIT. When honoured, the target becomes RUNNING and, one cycle after the issuing edge, `start_req` pulses with `start_core` = destination and `start_addr` = vector << 12. Otherwise it is ignored.
- R11: An asserting INIT, or a STARTUP, that comes from a core other than 0, or that targets core 0 or a core of N or more, raises `unhandled` and changes no boot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 = extended (single 64-bit write), 0 = compact |
| src_core | input | IDW | Index of the core sending the command |
| hi_wr | input | 1 | Compact-mode write of the upper half |
| hi_data | input | 32 | Upper-half data |
| lo_wr | input | 1 | Compact-mode write of the lower half; issues the command |
| lo_data | input | 32 | Lower-half data |
| cmd_wr | input | 1 | Extended-mode command write |
| cmd_data | input | 64 | Extended-mode command |
| fix_req | output | N | One-hot fixed-interrupt request to the core being served |
| fix_vec | output | 8 | Vector that goes with `fix_req` |
| nmi_pulse | output | N | One-hot NMI to the core being served |
| start_req | output | 1 | Start request pulse |
| start_core | output | IDW | Core to start |
| start_addr | output | 20 | Start address (vector << 12) |
| unhandled | output | 1 | Pulse for a command the block does not handle |
| busy | output | 1 | Fan-out in progress |
| core_state | output | 2N | Per-core boot state |

## Verification
The assertions assume the sender drives only one of `hi_wr`, `lo_wr` and `cmd_wr` per cycle. They also assume `src_core` is below N and that `ext_mode` does not change in the cycle a command issues. The bench respects all three by construction: every command comes from a task that drives one strobe on the falling edge, with the mode and source set at the same time, and the bench only issues a command after `busy` has dropped. The one exception is the directed test that deliberately issues a command during a fan-out to show it is dropped. The table runs through the boot sequence in a fixed order, so the shorthand cases see a known set of RUNNING cores.

// File: rtl/ipi_seq_pkg.sv
`timescale 1ns/1ps
package ipi_seq_pkg;

    typedef enum logic [1:0] {
        BOOT_INIT = 2'b00,
        BOOT_WAIT = 2'b01,
        BOOT_RUN  = 2'b10
    } boot_e;

    localparam logic [2:0] DM_FIXED = 3'b000;
    localparam logic [2:0] DM_NMI   = 3'b100;
    localparam logic [2:0] DM_INIT  = 3'b101;
    localparam logic [2:0] DM_START = 3'b110;

    localparam logic [1:0] SH_DEST  = 2'b00;
    localparam logic [1:0] SH_SELF  = 2'b01;
    localparam logic [1:0] SH_ALL   = 2'b10;
    localparam logic [1:0] SH_OTHER = 2'b11;

    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int LEVEL_BIT = 14;
    localparam int SH_LSB    = 18;

endpackage

// File: rtl/ipi_cmd_assembler.sv
`timescale 1ns/1ps
module ipi_cmd_assembler (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_mode,
    input  logic        hi_wr,
    input  logic [31:0] hi_data,
    input  logic        lo_wr,
    input  logic [31:0] lo_data,
    input  logic        cmd_wr,
    input  logic [63:0] cmd_data,
    output logic        issue,
    output logic [63:0] cmd
);
    logic [31:0] hi_d, hi_q;

    always_comb begin
        hi_d = hi_q;
        if (!ext_mode && hi_wr) hi_d = hi_data;
        issue = ext_mode ? cmd_wr : lo_wr;
        cmd   = ext_mode ? cmd_data : {hi_q, lo_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
    end

    AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode || !hi_wr) |=> $stable(hi_q)); // R3

endmodule

// File: rtl/ipi_boot_tracker.sv
`timescale 1ns/1ps
module ipi_boot_tracker
    import ipi_seq_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   to_wait,
    input  logic [N-1:0]   to_run,
    output logic [2*N-1:0] state_flat,
    output logic [N-1:0]   running
);
    boot_e st_d [N];
    boot_e st_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            st_d[i] = st_q[i];
            if (to_wait[i] && st_q[i] == BOOT_INIT) st_d[i] = BOOT_WAIT;
            if (to_run[i]  && st_q[i] == BOOT_WAIT) st_d[i] = BOOT_RUN;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) st_q[i] <= (i == 0) ? BOOT_RUN : BOOT_INIT;
            else        st_q[i] <= st_d[i];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_core
        assign state_flat[2*g +: 2] = st_q[g];
        assign running[g]           = (st_q[g] == BOOT_RUN);

        AST_RUN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] == BOOT_RUN |=> st_q[g] == BOOT_RUN); // R10
        AST_WAIT_ONLY_FROM_INIT: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] == BOOT_RUN |=> st_q[g] != BOOT_WAIT); // R9
    end

endmodule

// File: rtl/ipi_fanout.sv
`timescale 1ns/1ps
module ipi_fanout #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_mask,
    output logic [N-1:0] grant,
    output logic         busy
);
    logic [N-1:0] mask_d, mask_q;

    always_comb begin
        grant = mask_q & (~mask_q + 1'b1);
        busy  = |mask_q;
        if (load) mask_d = load_mask;
        else      mask_d = mask_q & ~grant;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7
    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> $countones(mask_q) == $countones($past(mask_q)) - 1); // R7
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R7

endmodule

// File: rtl/ipi_sequencer.sv
`timescale 1ns/1ps
module ipi_sequencer
    import ipi_seq_pkg::*;
#(
    parameter int N          = 4,
    parameter int VECW       = 8,
    parameter int PAGE_SHIFT = 12,
    localparam int IDW       = (N > 1) ? $clog2(N) : 1,
    localparam int ADDRW     = VECW + PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic [IDW-1:0]   src_core,
    input  logic             hi_wr,
    input  logic [31:0]      hi_data,
    input  logic             lo_wr,
    input  logic [31:0]      lo_data,
    input  logic             cmd_wr,
    input  logic [63:0]      cmd_data,
    output logic [N-1:0]     fix_req,
    output logic [VECW-1:0]  fix_vec,
    output logic [N-1:0]     nmi_pulse,
    output logic             start_req,
    output logic [IDW-1:0]   start_core,
    output logic [ADDRW-1:0] start_addr,
    output logic             unhandled,
    output logic             busy,
    output logic [2*N-1:0]   core_state
);
    typedef struct packed {
        logic [VECW-1:0]  vec;
        logic             nmi;
        logic             start;
        logic [IDW-1:0]   core;
        logic [ADDRW-1:0] addr;
        logic             unh;
    } seq_t;

    seq_t s_d, s_q;

    logic        issue;
    logic [63:0] cmd;
    logic [N-1:0] running, grant, to_wait, to_run, sel, load_mask;
    logic        load;

    // decoded fields
    logic [VECW-1:0] vec;
    logic [2:0]      mode;
    logic            level, go, from_boot, dest_ok, dest_lt;
    logic [1:0]      sh;
    logic [31:0]     dest;
    logic [IDW-1:0]  dest_idx;
    logic [N-1:0]    dest_1h, self_1h;
    logic [1:0]      tgt_state;
    logic            unused_bits;

    ipi_cmd_assembler u_asm (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .hi_wr(hi_wr), .hi_data(hi_data), .lo_wr(lo_wr), .lo_data(lo_data),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .issue(issue), .cmd(cmd)
    );

    ipi_boot_tracker #(.N(N)) u_boot (
        .clk(clk), .rst_n(rst_n), .to_wait(to_wait), .to_run(to_run),
        .state_flat(core_state), .running(running)
    );

    ipi_fanout #(.N(N)) u_fan (
        .clk(clk), .rst_n(rst_n), .load(load), .load_mask(load_mask),
        .grant(grant), .busy(busy)
    );

    assign unused_bits = ^{cmd[31:20], cmd[17:15], cmd[13:11]};

    always_comb begin
        vec      = cmd[VEC_LSB +: VECW];
        mode     = cmd[MODE_LSB +: 3];
        level    = cmd[LEVEL_BIT];
        sh       = cmd[SH_LSB +: 2];
        dest     = ext_mode ? cmd[63:32] : {24'b0, cmd[63:56]};
        dest_lt  = dest < 32'(N);
        dest_ok  = dest_lt && (dest != 32'd0);
        dest_idx = dest[IDW-1:0];
        dest_1h  = dest_lt ? (N'(1) << dest_idx) : '0;
        self_1h  = N'(1) << src_core;
        go       = issue && !busy;
        from_boot = (src_core == '0) && dest_ok;
        tgt_state = dest_lt ? core_state[2*int'(dest_idx) +: 2] : BOOT_INIT;

        case (sh)
            SH_DEST:  sel = dest_1h;
            SH_SELF:  sel = self_1h;
            SH_ALL:   sel = running;
            default:  sel = running & ~self_1h;
        endcase

        load      = go && (mode == DM_FIXED || mode == DM_NMI) && (sel != '0);
        load_mask = sel;
        to_wait   = (go && mode == DM_INIT && level && from_boot) ? dest_1h : '0;
        to_run    = (go && mode == DM_START && from_boot) ? dest_1h : '0;

        s_d       = s_q;
        s_d.start = go && mode == DM_START && from_boot && tgt_state == BOOT_WAIT;
        s_d.core  = dest_idx;
        s_d.addr  = ADDRW'(vec) << PAGE_SHIFT;
        if (!s_d.start) begin
            s_d.core = s_q.core;
            s_d.addr = s_q.addr;
        end
        s_d.unh = go && (
                  !(mode == DM_FIXED || mode == DM_NMI || mode == DM_INIT || mode == DM_START)
                  || (((mode == DM_INIT && level) || mode == DM_START) && !from_boot));
        if (load) begin
            s_d.vec = vec;
            s_d.nmi = (mode == DM_NMI);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fix_req    = s_q.nmi ? '0 : grant;
    assign nmi_pulse  = s_q.nmi ? grant : '0;
    assign fix_vec    = s_q.vec;
    assign start_req  = s_q.start;
    assign start_core = s_q.core;
    assign start_addr = s_q.addr;
    assign unhandled  = s_q.unh;

    AST_CORE0_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        core_state[1:0] == BOOT_RUN); // R1
    AST_START_LEAVES_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> core_state[2*int'(start_core) +: 2] == BOOT_RUN); // R10
    AST_START_NOT_CORE0: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> start_core != '0); // R11
    AST_UNH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |-> !start_req && !busy); // R4
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(fix_req != '0 && nmi_pulse != '0)); // R8

endmodule

// File: tb/ipi_sequencer_tb.sv
`timescale 1ns/1ps
module ipi_sequencer_tb;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [1:0]  src_core = '0;
    logic        hi_wr = 1'b0, lo_wr = 1'b0, cmd_wr = 1'b0;
    logic [31:0] hi_data = '0, lo_data = '0;
    logic [63:0] cmd_data = '0;
    logic [3:0]  fix_req, nmi_pulse;
    logic [7:0]  fix_vec;
    logic        start_req, unhandled, busy;
    logic [1:0]  start_core;
    logic [19:0] start_addr;
    logic [7:0]  core_state;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ipi_sequencer #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .src_core(src_core),
        .hi_wr(hi_wr), .hi_data(hi_data), .lo_wr(lo_wr), .lo_data(lo_data),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .fix_req(fix_req), .fix_vec(fix_vec),
        .nmi_pulse(nmi_pulse), .start_req(start_req), .start_core(start_core),
        .start_addr(start_addr), .unhandled(unhandled), .busy(busy),
        .core_state(core_state)
    );

    typedef struct packed {
        logic        ext;
        logic [1:0]  src;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [3:0]  efix;
        logic [3:0]  enmi;
        logic        est;
        logic [1:0]  ecore;
        logic [19:0] eaddr;
        logic        eunh;
        logic [7:0]  estate;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 32'h0000_0000, 32'h0008_0041, 4'b0001, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'h02}, // R6 all, only core0 runs
        '{1'b0, 2'd0, 32'h0200_0000, 32'h0000_4500, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'h12}, // R9 init core2
        '{1'b0, 2'd0, 32'h0100_0000, 32'h0000_0500, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'h12}, // R9 deassert ignored
        '{1'b0, 2'd0, 32'h0100_0000, 32'h0000_4612, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'h12}, // R10 core1 not waiting
        '{1'b1, 2'd0, 32'h0000_0002, 32'h0000_0634, 4'b0000, 4'b0000, 1'b1, 2'd2, 20'h34000, 1'b0, 8'h22}, // R10 start core2
        '{1'b1, 2'd0, 32'h0000_0003, 32'h0000_4500, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'h62}, // R9 init core3
        '{1'b1, 2'd0, 32'h0000_0003, 32'h0000_0699, 4'b0000, 4'b0000, 1'b1, 2'd3, 20'h99000, 1'b0, 8'hA2}, // R10 start core3
        '{1'b1, 2'd0, 32'h0000_0003, 32'h0000_0699, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R10 repeat ignored
        '{1'b1, 2'd0, 32'h0000_0002, 32'h0000_4500, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R9 init on running core
        '{1'b1, 2'd0, 32'h0000_0000, 32'h0008_0077, 4'b1101, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R7 three cores
        '{1'b0, 2'd2, 32'h0000_0000, 32'h000C_0400, 4'b0000, 4'b1001, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R8 nmi others
        '{1'b1, 2'd3, 32'h0000_0000, 32'h0004_0055, 4'b1000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R5 self
        '{1'b1, 2'd0, 32'h0000_0001, 32'h0000_0066, 4'b0010, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R5 explicit, not running
        '{1'b1, 2'd0, 32'h0000_0009, 32'h0000_0066, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R5 dest beyond N
        '{1'b1, 2'd0, 32'h0000_0000, 32'h0000_0100, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b1, 8'hA2}, // R4 mode 001
        '{1'b0, 2'd0, 32'h0000_0000, 32'h0000_0700, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b1, 8'hA2}, // R4 mode 111
        '{1'b1, 2'd1, 32'h0000_0001, 32'h0000_4500, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b1, 8'hA2}, // R11 sender not 0
        '{1'b1, 2'd0, 32'h0000_0000, 32'h0000_0600, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b1, 8'hA2}, // R11 dest 0
        '{1'b1, 2'd0, 32'h0100_0000, 32'h0000_0066, 4'b0000, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R3 wide dest
        '{1'b0, 2'd0, 32'h0100_0000, 32'h0000_0066, 4'b0010, 4'b0000, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}, // R2 dest [63:56]
        '{1'b1, 2'd0, 32'h0000_0002, 32'h0000_0400, 4'b0000, 4'b0100, 1'b0, 2'd0, 20'h00000, 1'b0, 8'hA2}  // R8 nmi explicit
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one command; ends on the negedge after the issuing edge
    task automatic issue(input logic ext, input logic [1:0] src, input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        ext_mode = ext;
        src_core = src;
        if (ext) begin
            cmd_wr = 1'b1; cmd_data = {hi, lo};
        end else begin
            hi_wr = 1'b1; hi_data = hi;
            @(negedge clk);
            hi_wr = 1'b0;
            lo_wr = 1'b1; lo_data = lo;
        end
        @(negedge clk);
        cmd_wr = 1'b0; lo_wr = 1'b0;
    endtask

    // observe the outcome starting at the current negedge
    task automatic collect(input vec_t v, input string tag, input bit inject);
        logic [3:0] fix_acc = '0, nmi_acc = '0;
        int nbusy = 0, last = -1;
        logic st = start_req, un = unhandled;
        logic [1:0]  sc = start_core;
        logic [19:0] sa = start_addr;
        bit order_ok = 1'b1, vec_ok = 1'b1;
        for (int k = 0; k < 16; k++) begin
            if (k > 0) begin
                st |= start_req; un |= unhandled;
            end
            if (!busy) break;
            nbusy++;
            for (int c = 0; c < N; c++) begin
                if (fix_req[c] || nmi_pulse[c]) begin
                    if (c <= last) order_ok = 1'b0;
                    last = c;
                end
            end
            if (fix_req != '0 && fix_vec != v.lo[7:0]) vec_ok = 1'b0;
            fix_acc |= fix_req;
            nmi_acc |= nmi_pulse;
            if (inject && k == 0) begin
                ext_mode = 1'b1; src_core = 2'd0;
                cmd_wr = 1'b1; cmd_data = 64'h0000_0000_0004_0400; // nmi self, dropped
            end
            @(negedge clk);
            cmd_wr = 1'b0;
        end
        check(fix_acc == v.efix, {tag, " fix set"}, 32'(fix_acc), 32'(v.efix));
        check(nmi_acc == v.enmi, {tag, " nmi set"}, 32'(nmi_acc), 32'(v.enmi));
        check(nbusy == $countones(v.efix | v.enmi), {tag, " R7 busy cycles"},
              32'(nbusy), 32'($countones(v.efix | v.enmi)));
        check(order_ok, {tag, " R7 ascending"}, 32'(order_ok), 32'd1);
        check(vec_ok, {tag, " R5 vector"}, 32'(fix_vec), 32'(v.lo[7:0]));
        check(st == v.est, {tag, " start_req"}, 32'(st), 32'(v.est));
        if (v.est) begin
            check(sc == v.ecore, {tag, " R10 start_core"}, 32'(sc), 32'(v.ecore));
            check(sa == v.eaddr, {tag, " R10 start_addr"}, 32'(sa), 32'(v.eaddr));
        end
        check(un == v.eunh, {tag, " unhandled"}, 32'(un), 32'(v.eunh));
        check(core_state == v.estate, {tag, " boot state"}, 32'(core_state), 32'(v.estate));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(core_state == 8'h02, "R1 boot state", 32'(core_state), 32'h02);
        check({busy, start_req, unhandled} == 3'b000 && fix_req == 0 && nmi_pulse == 0,
              "R1 idle outputs", 32'({busy, start_req, unhandled, fix_req, nmi_pulse}), 32'd0);

        // R2 high-half write alone does nothing
        ext_mode = 1'b0; hi_wr = 1'b1; hi_data = 32'h0100_0000;
        @(negedge clk);
        hi_wr = 1'b0;
        check({busy, start_req, unhandled} == 3'b000, "R2 hi write silent",
              32'({busy, start_req, unhandled}), 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].ext, TBL[i].src, TBL[i].hi, TBL[i].lo);
            collect(TBL[i], $sformatf("vec%0d", i), 1'b0);
        end

        // R7 command during fan-out is dropped
        v = '{1'b1, 2'd0, 32'h0, 32'h0008_0077, 4'b1101, 4'b0000, 1'b0, 2'd0, 20'h0, 1'b0, 8'hA2};
        issue(1'b1, 2'd0, 32'h0, 32'h0008_0077);
        collect(v, "R7 busy drop", 1'b1);
        check(busy == 1'b0 && nmi_pulse == '0, "R7 dropped stays dropped",
              32'({busy, nmi_pulse}), 32'd0);

        // R3 hi_wr ignored in extended mode
        @(negedge clk);
        ext_mode = 1'b0; hi_wr = 1'b1; hi_data = 32'h0100_0000;
        @(negedge clk);
        ext_mode = 1'b1; hi_data = 32'h0200_0000;
        @(negedge clk);
        hi_wr = 1'b0; ext_mode = 1'b0; lo_wr = 1'b1; lo_data = 32'h0000_0066;
        @(negedge clk);
        lo_wr = 1'b0;
        v = '{1'b0, 2'd0, 32'h0, 32'h0000_0066, 4'b0010, 4'b0000, 1'b0, 2'd0, 20'h0, 1'b0, 8'hA2};
        collect(v, "R3 ext hi ignored", 1'b0);

        // R3 lo_wr ignored in extended mode
        ext_mode = 1'b1; lo_wr = 1'b1; lo_data = 32'h0004_0055;
        @(negedge clk);
        lo_wr = 1'b0;
        check(busy == 1'b0 && fix_req == '0, "R3 ext lo ignored", 32'({busy, fix_req}), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule